// File: doc/BRIEF.md
# Pipelined Two-Level Status-Line Combiner

This block stands in, in synchronous logic, for the shared open-collector status lines of a bus that several arbiters use: an ownership line, a sharing line and a stop line. Every device behind an arbiter pulls its own active-low request. For the sharing and stop lines the block forms two results. The first is the OR of one arbiter's devices, which goes back to that arbiter one cycle after sampling. The second is the OR across all arbiters, which goes back to every arbiter three cycles after sampling.

The ownership line has no device level. Each arbiter drives one bit. The system-wide OR of those bits appears on a common line one cycle later and at every arbiter's input three cycles later. All three lines are separate instances of one parametric tree, so they share the same timing.

Sampled results are written into a ten-entry history ring that is indexed by the cycle count modulo its depth. Reset empties the ring to the inactive level. This lets a system model run the arbiters against the same bus behaviour the real lines would give.

Top module: `bus_status_fabric`

## Requirements
- R1: Every request and every result is active low. A low input bit asserts a request, and when no request is asserted on a line, every result of that line is high.
- R2: For the sharing and stop lines, result bit a of `*_arb_n` is low in the cycle after the edge that sampled a low on any of arbiter a's request bits, which are bits a*N_DEV to a*N_DEV+N_DEV-1. Other arbiters' bits are not affected.
- R3: For the sharing and stop lines, every bit of `*_in_n` equals the OR of all that line's requests sampled three edges earlier, and all bits carry the same value.
- R4: On the ownership line, `own_bus_n` is low in the cycle after an edge that sampled a low on any bit of `own_req_n`.
- R5: On the ownership line, every bit of `own_in_n` is low exactly three edges after an edge that sampled a low on any bit of `own_req_n`.
- R6: While `rst_n` is low, and in the cycle after its release before any sample has propagated, all outputs are high, whatever the request inputs are.
- R7: The three lines are independent. Requests on one line never change the results of another line.
- R8: A new request pattern can be applied on every cycle. Each pattern's one-cycle and three-cycle results appear in order, with none lost or repeated.
- R9: A request held low for one cycle produces results that are low for exactly one cycle, at the latencies of R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_req_n | input | N_ARB | Ownership request, one bit per arbiter |
| own_bus_n | output | 1 | Common ownership line, one cycle after sampling |
| own_in_n | output | N_ARB | Ownership line seen by each arbiter, three cycles after sampling |
| shr_req_n | input | N_ARB*N_DEV | Sharing requests, N_DEV bits per arbiter |
| shr_arb_n | output | N_ARB | Per-arbiter sharing OR, one cycle after sampling |
| shr_in_n | output | N_ARB | System sharing OR to every arbiter, three cycles after sampling |
| stp_req_n | input | N_ARB*N_DEV | Stop requests, N_DEV bits per arbiter |
| stp_arb_n | output | N_ARB | Per-arbiter stop OR, one cycle after sampling |
| stp_in_n | output | N_ARB | System stop OR to every arbiter, three cycles after sampling |

## Verification
In every cycle the one-cycle result of the newest pattern and the three-cycle result of a pattern two samples older leave the block together, and both are read from the same history ring. The bench provokes this by changing the request pattern on every clock: one-hot sweeps over all device bits, single-cycle pulses and random words. A wrong read index or a stale entry then shows up as a mismatch on one of the two outputs. The scoreboard keeps two separate queues of expected results, one due one cycle after sampling and one due three cycles after. In each cycle it compares both against the ports, so the two functions are judged in the same cycle but independently of each other.

// File: rtl/wor_tree.sv
module wor_tree #(
  parameter int N_ARB   = 4,
  parameter int N_DEV   = 3,
  parameter int PER_DEV = 1,
  parameter int DEPTH   = 10,
  localparam int N_IN   = PER_DEV != 0 ? N_ARB * N_DEV : N_ARB,
  localparam int N_MID  = PER_DEV != 0 ? N_ARB : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  dev_n,
  output logic [N_MID-1:0] mid_n,
  output logic [N_ARB-1:0] sys_n
);
  localparam int PW = $clog2(DEPTH);

  logic [N_MID-1:0] mid_act;
  logic             sys_act;
  logic [N_MID-1:0] mid_ring [DEPTH];
  logic [DEPTH-1:0] sys_ring;
  logic [PW-1:0]    wp, rd1, rd3;
  logic [1:0]       age;

  generate
    if (PER_DEV != 0) begin : g_dev
      for (genvar a = 0; a < N_ARB; a++) begin : g_arb
        assign mid_act[a] = ~&dev_n[a*N_DEV +: N_DEV];
      end
    end else begin : g_flat
      assign mid_act[0] = ~&dev_n;
    end
  endgenerate

  assign sys_act = |mid_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      sys_ring <= '0;
      for (int i = 0; i < DEPTH; i++) mid_ring[i] <= '0;
    end else begin
      mid_ring[wp] <= mid_act;
      sys_ring[wp] <= sys_act;
      wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
    end
  end

  assign rd1   = PW'((32'(wp) + DEPTH - 1) % DEPTH);
  assign rd3   = PW'((32'(wp) + DEPTH - 3) % DEPTH);
  assign mid_n = ~mid_ring[rd1];
  assign sys_n = {N_ARB{~sys_ring[rd3]}};

  always_ff @(posedge clk) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd0 |-> (&mid_n) && (&sys_n));

  generate
    if (PER_DEV != 0) begin : g_chk_dev
      for (genvar a = 0; a < N_ARB; a++) begin : g_arb
        p_arb_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
          age != 2'd0 |-> mid_n[a] == &$past(dev_n[a*N_DEV +: N_DEV]));
      end
    end else begin : g_chk_flat
      p_bus_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        age != 2'd0 |-> mid_n[0] == &$past(dev_n));
    end
  endgenerate

  p_sys_three_r3: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 |-> sys_n == {N_ARB{&$past(dev_n, 3)}});

  p_sys_follows_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 |-> sys_n[0] == &$past(mid_n, 2));
endmodule

// File: rtl/bus_status_fabric.sv
module bus_status_fabric #(
  parameter int N_ARB = 4,
  parameter int N_DEV = 3,
  parameter int DEPTH = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ARB-1:0]       own_req_n,
  output logic                   own_bus_n,
  output logic [N_ARB-1:0]       own_in_n,
  input  logic [N_ARB*N_DEV-1:0] shr_req_n,
  output logic [N_ARB-1:0]       shr_arb_n,
  output logic [N_ARB-1:0]       shr_in_n,
  input  logic [N_ARB*N_DEV-1:0] stp_req_n,
  output logic [N_ARB-1:0]       stp_arb_n,
  output logic [N_ARB-1:0]       stp_in_n
);
  wor_tree #(.N_ARB(N_ARB), .N_DEV(1), .PER_DEV(0), .DEPTH(DEPTH)) u_own (
    .clk(clk), .rst_n(rst_n), .dev_n(own_req_n),
    .mid_n(own_bus_n), .sys_n(own_in_n));

  wor_tree #(.N_ARB(N_ARB), .N_DEV(N_DEV), .PER_DEV(1), .DEPTH(DEPTH)) u_shr (
    .clk(clk), .rst_n(rst_n), .dev_n(shr_req_n),
    .mid_n(shr_arb_n), .sys_n(shr_in_n));

  wor_tree #(.N_ARB(N_ARB), .N_DEV(N_DEV), .PER_DEV(1), .DEPTH(DEPTH)) u_stp (
    .clk(clk), .rst_n(rst_n), .dev_n(stp_req_n),
    .mid_n(stp_arb_n), .sys_n(stp_in_n));
endmodule

// File: tb/bus_status_fabric_test.sv
module bus_status_fabric_test;
  localparam int NA = 4;
  localparam int ND = 3;
  localparam int NI = NA * ND;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NA-1:0] own_req_n = '1;
  logic [NI-1:0] shr_req_n = '1, stp_req_n = '1;
  logic own_bus_n;
  logic [NA-1:0] own_in_n, shr_arb_n, shr_in_n, stp_arb_n, stp_in_n;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_status_fabric #(.N_ARB(NA), .N_DEV(ND), .DEPTH(10)) uut (
    .clk(clk), .rst_n(rst_n),
    .own_req_n(own_req_n), .own_bus_n(own_bus_n), .own_in_n(own_in_n),
    .shr_req_n(shr_req_n), .shr_arb_n(shr_arb_n), .shr_in_n(shr_in_n),
    .stp_req_n(stp_req_n), .stp_arb_n(stp_arb_n), .stp_in_n(stp_in_n));

  typedef struct {
    int            due;
    logic [NA-1:0] own;
    logic [NA-1:0] shr;
    logic [NA-1:0] stp;
    string         tag;
  } exp_t;

  exp_t q_one[$];
  exp_t q_three[$];

  function automatic logic [NA-1:0] per_arb(input logic [NI-1:0] v);
    logic [NA-1:0] r;
    for (int a = 0; a < NA; a++) r[a] = &v[a*ND +: ND];
    return r;
  endfunction

  task automatic chk(input logic [NA-1:0] act, input logic [NA-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", what, cyc, act, exp);
    end
  endtask

  task automatic drive(input logic [NA-1:0] own, input logic [NI-1:0] shr,
                       input logic [NI-1:0] stp, input string tag);
    exp_t m, s;
    @(negedge clk);
    own_req_n = own; shr_req_n = shr; stp_req_n = stp;
    m.due = cyc + 1; m.own = {NA{&own}}; m.shr = per_arb(shr); m.stp = per_arb(stp); m.tag = tag;
    s.due = cyc + 3; s.own = {NA{&own}}; s.shr = {NA{&shr}};   s.stp = {NA{&stp}};   s.tag = tag;
    q_one.push_back(m);
    q_three.push_back(s);
  endtask

  // Scoreboard monitor: one-cycle and three-cycle results are judged in the same cycle.
  always @(negedge clk) begin
    #1;
    if (q_one.size() != 0 && q_one[0].due == cyc) begin
      exp_t e;
      e = q_one.pop_front();
      chk({{(NA-1){1'b0}}, own_bus_n}, {{(NA-1){1'b0}}, e.own[0]}, {"R4 own_bus_n ", e.tag});
      chk(shr_arb_n, e.shr, {"R2 shr_arb_n ", e.tag});
      chk(stp_arb_n, e.stp, {"R2 stp_arb_n ", e.tag});
    end
    if (q_three.size() != 0 && q_three[0].due == cyc) begin
      exp_t e;
      e = q_three.pop_front();
      chk(own_in_n, e.own, {"R5 own_in_n ", e.tag});
      chk(shr_in_n, e.shr, {"R3 shr_in_n ", e.tag});
      chk(stp_in_n, e.stp, {"R3 stp_in_n ", e.tag});
    end
  end

  task automatic chk_all_high(input string what);
    chk({{(NA-1){1'b0}}, own_bus_n}, {{(NA-1){1'b0}}, 1'b1}, what);
    chk(own_in_n, '1, what);
    chk(shr_arb_n, '1, what); chk(shr_in_n, '1, what);
    chk(stp_arb_n, '1, what); chk(stp_in_n, '1, what);
  endtask

  initial begin
    // R6: requests asserted during reset must not reach the outputs
    own_req_n = '0; shr_req_n = '0; stp_req_n = '0;
    repeat (4) @(negedge clk);
    #1 chk_all_high("R6 during reset");
    own_req_n = '1; shr_req_n = '1; stp_req_n = '1;
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk_all_high("R6 after release");

    // R1: idle lines stay high
    drive('1, '1, '1, "R1 idle");
    drive('1, '1, '1, "R1 idle");

    // R2/R8: one-hot sweep of every device bit on sharing, back to back
    for (int i = 0; i < NI; i++) drive('1, ~(NI'(1) << i), '1, "R8 shr sweep");
    // R7: stop-only activity leaves sharing and ownership untouched
    for (int i = 0; i < NI; i++) drive('1, '1, ~(NI'(1) << i), "R7 stp only");
    // R4/R5: ownership from each arbiter alone
    for (int a = 0; a < NA; a++) drive(~(NA'(1) << a), '1, '1, "R5 own single");

    // R9: single-cycle pulses with idle gaps
    drive('1, ~NI'(1 << 4), '1, "R9 pulse");
    drive('1, '1, '1, "R9 gap");
    drive('1, '1, '1, "R9 gap");
    drive(~NA'(2), '1, ~NI'(1 << 11), "R9 pulse");
    drive('1, '1, '1, "R9 gap");
    drive('1, '1, '1, "R9 gap");
    drive('1, '1, '1, "R9 gap");

    // R1: several arbiters and devices asserted together
    drive('0, '0, '0, "R1 all active");
    drive(4'b1010, 12'b110_011_111_000, 12'b011_111_101_111, "R1 mixed");

    // R8: random words changing every cycle
    for (int k = 0; k < 300; k++)
      drive(NA'($urandom), NI'($urandom), NI'($urandom), "R8 random");

    for (int k = 0; k < 4; k++) drive('1, '1, '1, "R8 drain");
    repeat (4) @(negedge clk);
    #2;
    chk(NA'(q_one.size() + q_three.size()), '0, "R8 queues empty");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule